// File: doc/BRIEF.md
# Tagged Floating-Point Register Stack Controller

This block keeps an eight-slot circular stack of opaque 80-bit register words. Each slot has a 2-bit tag, and a 3-bit pointer marks the current top. A command port with a valid/ready handshake accepts four operations:

- **Push-load** takes a word and a tag supplied with the command.
- **Copy-load** pushes a duplicate of stack register ST(i).
- **Store** presents ST(0) on the store port, with an optional pop.
- **Store-to-register** copies ST(0) into ST(i), with an optional pop.

The slot tags alone tell the block that a stack fault has occurred. A slot that must be free but is occupied is an overflow. A slot that must hold a value but is empty is an underflow. There is no occupancy counter.

A per-command mask bit chooses the fault response. When the invalid exception is unmasked, the faulting command is abandoned and nothing changes. When it is masked, the block substitutes the indefinite encoding of the target format and the command still completes, including its pop. One exception is load overflow: it never changes state, whatever the mask. A condition flag (C1) records the load-overflow direction.

Top module: `fstk_ctrl`

## Requirements
- R1: After reset every slot is empty and the top pointer is 0. `tag_word` carries the tag of physical slot k in bits [2k+1:2k], so it reads 16'hFFFF. Tag codes are 0 valid, 1 zero, 2 special, 3 empty. `cmd_ready` is high once reset is low.
- R2: A push-load (op 0) moves the top pointer down by one modulo 8, so 0 becomes 7. It places `cmd_val` in the new ST(0) with tag `cmd_tag`.
- R3: If the slot one below the top is not empty, any load (op 0 or 1) reports `rsp_fault` and `rsp_ovf`, sets C1 to 1, and does not complete. Top, tags and data are left untouched whether or not the command is masked.
- R4: A copy-load (op 1) pushes the word and tag of ST(`cmd_idx`). If that source is empty it raises an underflow fault, but only after the overflow test has passed.
  - Unmasked, the underflow changes nothing.
  - Masked, it pushes the extended indefinite 80'hFFFF_C000_0000_0000_0000 with tag special and completes.
- R5: A load that does not overflow leaves C1 at 0.
- R6: A store (op 2) with ST(0) occupied raises `st_we` and presents the ST(0) word on `st_data`. When `cmd_pop` is set it then marks the old top empty and moves the top pointer up by one modulo 8.
- R7: A store or store-to-register with ST(0) empty and `cmd_mask` low reports `rsp_fault` and does not complete. It does not write and does not pop.
- R8: A store with ST(0) empty and `cmd_mask` high reports `rsp_fault`, completes, and writes the indefinite value of the format `cmd_fmt`, zero-extended to 80 bits. It pops as requested. The indefinite values are:
  - formats 0 (extended) and 6 (decimal): FFFF_C000_0000_0000_0000
  - format 1 (64-bit float): FFF8_0000_0000_0000
  - format 2 (32-bit float): FFC0_0000
  - format 3 (16-bit integer): 8000
  - format 4 (32-bit integer): 8000_0000
  - format 5 (64-bit integer): 8000_0000_0000_0000
- R9: A store in format 0, 5 or 6 always pops. A store with `cmd_trunc` set in an integer format (3, 4, 5) also always pops.
- R10: A store-to-register (op 3) writes the ST(0) word and tag into ST(`cmd_idx`) and then pops if `cmd_pop` is set. Popping with index 0 leaves that slot empty.
- R11: Every accepted command gives exactly one `rsp_valid` pulse, on the clock edge that accepts it. All response outputs and state outputs change on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | 0 push-load, 1 copy-load, 2 store, 3 store-to-register |
| cmd_idx | input | 3 | Stack-relative register index i |
| cmd_pop | input | 1 | Pop after store |
| cmd_trunc | input | 1 | Truncating integer store (forces pop) |
| cmd_fmt | input | 3 | Store format code |
| cmd_mask | input | 1 | Invalid exception masked |
| cmd_val | input | 80 | Word for push-load |
| cmd_tag | input | 2 | Tag for push-load |
| rsp_valid | output | 1 | Response for the last accepted command |
| rsp_done | output | 1 | Command completed |
| rsp_fault | output | 1 | Invalid-operation stack fault raised |
| rsp_ovf | output | 1 | Fault was an overflow |
| st_we | output | 1 | Store data valid |
| st_data | output | 80 | Stored word |
| c1 | output | 1 | Condition flag C1 |
| top_ptr | output | 3 | Top-of-stack pointer |
| tag_word | output | 16 | All slot tags, slot k at bits [2k+1:2k] |

## Verification
Every result of a command lands on the one rising edge that accepts it. That includes the response flags, store data, C1, the top pointer and the tag word, so each is due exactly one cycle after the command is presented.

The bench drives a command on a falling edge and holds it across one rising edge. It removes the command and reads every output on the next falling edge, half a cycle after they settle and before any later command can disturb them.

State that is not on a port, such as slot contents, is read back through later stores. Tag changes are read from the tag word in the same sampling window.

// File: rtl/fstk_pkg.sv
package fstk_pkg;

    localparam int STK_SLOTS = 8;
    localparam int STK_PTR_W = $clog2(STK_SLOTS);
    localparam int STK_VAL_W = 80;
    localparam int STK_TAG_W = 2;

    typedef logic [STK_PTR_W-1:0] slot_t;
    typedef logic [STK_VAL_W-1:0] word_t;

    typedef enum logic [STK_TAG_W-1:0] {
        TAG_VALID   = 2'd0,
        TAG_ZERO    = 2'd1,
        TAG_SPECIAL = 2'd2,
        TAG_EMPTY   = 2'd3
    } tag_e;

    typedef enum logic [1:0] {
        OP_PUSH_LD   = 2'd0,
        OP_COPY_LD   = 2'd1,
        OP_STORE     = 2'd2,
        OP_STORE_REG = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        FMT_EXT  = 3'd0,
        FMT_F64  = 3'd1,
        FMT_F32  = 3'd2,
        FMT_I16  = 3'd3,
        FMT_I32  = 3'd4,
        FMT_I64  = 3'd5,
        FMT_BCD  = 3'd6,
        FMT_RSVD = 3'd7
    } fmt_e;

    localparam word_t EXT_INDEF = word_t'({16'hFFFF, 64'hC000_0000_0000_0000});

    // Masked-response value for each store format, zero-extended.
    function automatic word_t indefinite(fmt_e f);
        word_t r;
        case (f)
            FMT_F64: r = word_t'(64'hFFF8_0000_0000_0000);
            FMT_F32: r = word_t'(32'hFFC0_0000);
            FMT_I16: r = word_t'(16'h8000);
            FMT_I32: r = word_t'(32'h8000_0000);
            FMT_I64: r = word_t'(64'h8000_0000_0000_0000);
            default: r = EXT_INDEF;
        endcase
        return r;
    endfunction

    // Formats whose store always releases ST(0).
    function automatic logic forced_pop(fmt_e f, logic trunc);
        logic always_p;
        logic int_fmt;
        always_p = (f == FMT_EXT) || (f == FMT_I64) || (f == FMT_BCD) || (f == FMT_RSVD);
        int_fmt  = (f == FMT_I16) || (f == FMT_I32) || (f == FMT_I64);
        return always_p || (trunc && int_fmt);
    endfunction

    typedef struct packed {
        logic  done;
        logic  fault;
        logic  ovf;
        logic  push;
        logic  pop;
        logic  wr_en;
        slot_t wr_slot;
        word_t wr_val;
        tag_e  wr_tag;
        logic  st_we;
        word_t st_data;
        logic  c1_we;
        logic  c1_val;
    } plan_t;

endpackage

// File: rtl/fstk_tagfile.sv
module fstk_tagfile
    import fstk_pkg::*;
#(
    parameter int SLOTS = STK_SLOTS,
    localparam int PW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_slot,
    input  tag_e          wr_tag,
    output logic [PW-1:0] top,
    output tag_e          tags [SLOTS]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < SLOTS; k++) begin
                tags[k] <= TAG_EMPTY;
            end
            top <= '0;
        end else begin
            if (wr_en) begin
                tags[wr_slot] <= wr_tag;
            end
            // A pop releases the old top; it overrides a write to the same slot.
            if (pop) begin
                tags[top] <= TAG_EMPTY;
            end
            if (push) begin
                top <= top - 1'b1;
            end else if (pop) begin
                top <= top + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fstk_valfile.sv
module fstk_valfile #(
    parameter int SLOTS = 8,
    parameter int W     = 80,
    localparam int PW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_slot,
    input  logic [W-1:0]  wr_val,
    input  logic [PW-1:0] rd_a_slot,
    output logic [W-1:0]  rd_a,
    input  logic [PW-1:0] rd_b_slot,
    output logic [W-1:0]  rd_b
);

    logic [W-1:0] mem [SLOTS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_slot] <= wr_val;
        end
    end

    assign rd_a = mem[rd_a_slot];
    assign rd_b = mem[rd_b_slot];

endmodule

// File: rtl/fstk_plan.sv
module fstk_plan
    import fstk_pkg::*;
(
    input  logic  fire,
    input  op_e   op,
    input  slot_t top_slot,
    input  slot_t below_slot,
    input  slot_t sti_slot,
    input  logic  pop_req,
    input  logic  mask,
    input  fmt_e  fmt,
    input  logic  trunc,
    input  word_t ld_val,
    input  tag_e  ld_tag,
    input  tag_e  tags [STK_SLOTS],
    input  word_t st0_val,
    input  word_t sti_val,
    output plan_t plan
);

    logic st0_empty;
    logic sti_empty;
    logic below_busy;
    logic pop_eff;

    assign st0_empty  = (tags[top_slot] == TAG_EMPTY);
    assign sti_empty  = (tags[sti_slot] == TAG_EMPTY);
    assign below_busy = (tags[below_slot] != TAG_EMPTY);
    assign pop_eff    = pop_req || forced_pop(fmt, trunc);

    always_comb begin
        plan        = '0;
        plan.wr_tag = TAG_EMPTY;
        if (fire) begin
            case (op)
                OP_PUSH_LD, OP_COPY_LD: begin
                    plan.c1_we   = 1'b1;
                    plan.wr_slot = below_slot;
                    if (below_busy) begin
                        plan.fault  = 1'b1;
                        plan.ovf    = 1'b1;
                        plan.c1_val = 1'b1;
                    end else if (op == OP_COPY_LD && sti_empty) begin
                        plan.fault = 1'b1;
                        if (mask) begin
                            plan.done   = 1'b1;
                            plan.push   = 1'b1;
                            plan.wr_en  = 1'b1;
                            plan.wr_val = EXT_INDEF;
                            plan.wr_tag = TAG_SPECIAL;
                        end
                    end else begin
                        plan.done   = 1'b1;
                        plan.push   = 1'b1;
                        plan.wr_en  = 1'b1;
                        plan.wr_val = (op == OP_COPY_LD) ? sti_val : ld_val;
                        plan.wr_tag = (op == OP_COPY_LD) ? tags[sti_slot] : ld_tag;
                    end
                end
                OP_STORE: begin
                    if (st0_empty) begin
                        plan.fault = 1'b1;
                        if (mask) begin
                            plan.done    = 1'b1;
                            plan.st_we   = 1'b1;
                            plan.st_data = indefinite(fmt);
                            plan.pop     = pop_eff;
                        end
                    end else begin
                        plan.done    = 1'b1;
                        plan.st_we   = 1'b1;
                        plan.st_data = st0_val;
                        plan.pop     = pop_eff;
                    end
                end
                default: begin
                    plan.wr_slot = sti_slot;
                    if (st0_empty) begin
                        plan.fault = 1'b1;
                        if (mask) begin
                            plan.done   = 1'b1;
                            plan.wr_en  = 1'b1;
                            plan.wr_val = EXT_INDEF;
                            plan.wr_tag = TAG_SPECIAL;
                            plan.pop    = pop_req;
                        end
                    end else begin
                        plan.done   = 1'b1;
                        plan.wr_en  = 1'b1;
                        plan.wr_val = st0_val;
                        plan.wr_tag = tags[top_slot];
                        plan.pop    = pop_req;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/fstk_ctrl.sv
module fstk_ctrl
    import fstk_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    output logic                     cmd_ready,
    input  logic [1:0]               cmd_op,
    input  logic [STK_PTR_W-1:0]     cmd_idx,
    input  logic                     cmd_pop,
    input  logic                     cmd_trunc,
    input  logic [2:0]               cmd_fmt,
    input  logic                     cmd_mask,
    input  logic [STK_VAL_W-1:0]     cmd_val,
    input  logic [STK_TAG_W-1:0]     cmd_tag,
    output logic                     rsp_valid,
    output logic                     rsp_done,
    output logic                     rsp_fault,
    output logic                     rsp_ovf,
    output logic                     st_we,
    output logic [STK_VAL_W-1:0]     st_data,
    output logic                     c1,
    output logic [STK_PTR_W-1:0]     top_ptr,
    output logic [STK_SLOTS*STK_TAG_W-1:0] tag_word
);

    slot_t top_q;
    slot_t below_slot;
    slot_t sti_slot;
    tag_e  tags_q [STK_SLOTS];
    word_t st0_val;
    word_t sti_val;
    plan_t plan;
    logic  fire;

    assign cmd_ready  = ~rst;
    assign fire       = cmd_valid && cmd_ready;
    assign below_slot = top_q - 1'b1;
    assign sti_slot   = top_q + cmd_idx;

    fstk_tagfile #(.SLOTS(STK_SLOTS)) u_tags (
        .clk     (clk),
        .rst     (rst),
        .push    (plan.push),
        .pop     (plan.pop),
        .wr_en   (plan.wr_en),
        .wr_slot (plan.wr_slot),
        .wr_tag  (plan.wr_tag),
        .top     (top_q),
        .tags    (tags_q)
    );

    fstk_valfile #(.SLOTS(STK_SLOTS), .W(STK_VAL_W)) u_vals (
        .clk       (clk),
        .wr_en     (plan.wr_en),
        .wr_slot   (plan.wr_slot),
        .wr_val    (plan.wr_val),
        .rd_a_slot (top_q),
        .rd_a      (st0_val),
        .rd_b_slot (sti_slot),
        .rd_b      (sti_val)
    );

    fstk_plan u_plan (
        .fire       (fire),
        .op         (op_e'(cmd_op)),
        .top_slot   (top_q),
        .below_slot (below_slot),
        .sti_slot   (sti_slot),
        .pop_req    (cmd_pop),
        .mask       (cmd_mask),
        .fmt        (fmt_e'(cmd_fmt)),
        .trunc      (cmd_trunc),
        .ld_val     (cmd_val),
        .ld_tag     (tag_e'(cmd_tag)),
        .tags       (tags_q),
        .st0_val    (st0_val),
        .sti_val    (sti_val),
        .plan       (plan)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_done  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_ovf   <= 1'b0;
            st_we     <= 1'b0;
            st_data   <= '0;
            c1        <= 1'b0;
        end else begin
            rsp_valid <= fire;
            rsp_done  <= plan.done;
            rsp_fault <= plan.fault;
            rsp_ovf   <= plan.ovf;
            st_we     <= plan.st_we;
            if (plan.st_we) begin
                st_data <= plan.st_data;
            end
            if (plan.c1_we) begin
                c1 <= plan.c1_val;
            end
        end
    end

    assign top_ptr = top_q;

    for (genvar g = 0; g < STK_SLOTS; g++) begin : g_tagw
        assign tag_word[g*STK_TAG_W +: STK_TAG_W] = tags_q[g];
    end

endmodule

// File: rtl/fstk_ctrl_chk.sv
module fstk_ctrl_chk
    import fstk_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     cmd_valid,
    input logic                     cmd_ready,
    input logic [1:0]               cmd_op,
    input logic [2:0]               cmd_fmt,
    input logic                     cmd_mask,
    input logic                     rsp_valid,
    input logic                     rsp_done,
    input logic                     rsp_fault,
    input logic                     rsp_ovf,
    input logic                     st_we,
    input logic                     c1,
    input logic [STK_PTR_W-1:0]     top_ptr,
    input logic [STK_SLOTS*STK_TAG_W-1:0] tag_word
);

    assert_resp_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> rsp_valid);

    assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_ready) |=> !rsp_valid);

    assert_ovf_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ovf) |-> (!rsp_done && c1 && $stable(top_ptr) && $stable(tag_word)));

    assert_push_top_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_done && !$past(cmd_op[1])) |-> (top_ptr == $past(top_ptr) - 3'd1));

    assert_c1_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !$past(cmd_op[1]) && !rsp_ovf) |-> !c1);

    assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault && !$past(cmd_mask)) |->
        (!rsp_done && !st_we && $stable(top_ptr) && $stable(tag_word)));

    assert_store_done_R6: assert property (@(posedge clk) disable iff (rst)
        st_we |-> (rsp_valid && rsp_done));

    assert_forced_pop_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_done && $past(cmd_op) == 2'd2 &&
         ($past(cmd_fmt) == 3'd0 || $past(cmd_fmt) == 3'd5 || $past(cmd_fmt) == 3'd6))
        |-> (top_ptr == $past(top_ptr) + 3'd1));

endmodule

bind fstk_ctrl fstk_ctrl_chk u_chk (.*);

// File: tb/fstk_ctrl_test.sv
`timescale 1ns/1ps
module fstk_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic [2:0]  cmd_idx = '0;
    logic        cmd_pop = 1'b0;
    logic        cmd_trunc = 1'b0;
    logic [2:0]  cmd_fmt = '0;
    logic        cmd_mask = 1'b0;
    logic [79:0] cmd_val = '0;
    logic [1:0]  cmd_tag = '0;
    logic        rsp_valid, rsp_done, rsp_fault, rsp_ovf, st_we, c1;
    logic [79:0] st_data;
    logic [2:0]  top_ptr;
    logic [15:0] tag_word;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fstk_ctrl uut (.*);

    localparam logic [79:0] VA  = 80'h3FFF_8000_0000_0000_0000;
    localparam logic [79:0] VB  = 80'h4001_C000_0000_0000_1234;
    localparam logic [79:0] VC  = 80'hBFFE_A000_0000_0000_5678;
    localparam logic [79:0] NAN = 80'hFFFF_C000_0000_0000_0000;
    localparam logic [79:0] Z   = 80'h0;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  idx;
        logic        pop;
        logic        mask;
        logic [2:0]  fmt;
        logic        trunc;
        logic [79:0] val;
        logic [1:0]  tag;
        logic        e_done;
        logic        e_fault;
        logic        e_we;
        logic [79:0] e_data;
        logic [2:0]  e_top;
        logic        chk_tags;
        logic [15:0] e_tags;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 3'd0, 1'b0, 1'b1, 3'd0, 1'b0, VA, 2'd0, 1'b1, 1'b0, 1'b0, Z,    3'd7, 1'b0, 16'h0},
        '{2'd0, 3'd0, 1'b0, 1'b1, 3'd0, 1'b0, VB, 2'd1, 1'b1, 1'b0, 1'b0, Z,    3'd6, 1'b0, 16'h0},
        '{2'd1, 3'd1, 1'b0, 1'b1, 3'd0, 1'b0, Z,  2'd0, 1'b1, 1'b0, 1'b0, Z,    3'd5, 1'b0, 16'h0},
        '{2'd2, 3'd0, 1'b0, 1'b1, 3'd1, 1'b0, Z,  2'd0, 1'b1, 1'b0, 1'b1, VA,   3'd5, 1'b0, 16'h0},
        '{2'd2, 3'd0, 1'b1, 1'b1, 3'd2, 1'b0, Z,  2'd0, 1'b1, 1'b0, 1'b1, VA,   3'd6, 1'b0, 16'h0},
        '{2'd1, 3'd5, 1'b0, 1'b0, 3'd0, 1'b0, Z,  2'd0, 1'b0, 1'b1, 1'b0, Z,    3'd6, 1'b0, 16'h0},
        '{2'd1, 3'd5, 1'b0, 1'b1, 3'd0, 1'b0, Z,  2'd0, 1'b1, 1'b1, 1'b0, Z,    3'd5, 1'b0, 16'h0},
        '{2'd2, 3'd0, 1'b0, 1'b1, 3'd0, 1'b0, Z,  2'd0, 1'b1, 1'b0, 1'b1, NAN,  3'd6, 1'b0, 16'h0},
        '{2'd3, 3'd1, 1'b1, 1'b1, 3'd0, 1'b0, Z,  2'd0, 1'b1, 1'b0, 1'b0, Z,    3'd7, 1'b1, 16'h7FFF},
        '{2'd2, 3'd0, 1'b0, 1'b1, 3'd3, 1'b0, Z,  2'd0, 1'b1, 1'b0, 1'b1, VB,   3'd7, 1'b0, 16'h0},
        '{2'd2, 3'd0, 1'b0, 1'b1, 3'd4, 1'b1, Z,  2'd0, 1'b1, 1'b0, 1'b1, VB,   3'd0, 1'b1, 16'hFFFF},
        '{2'd2, 3'd0, 1'b0, 1'b0, 3'd3, 1'b0, Z,  2'd0, 1'b0, 1'b1, 1'b0, Z,    3'd0, 1'b0, 16'h0},
        '{2'd2, 3'd0, 1'b0, 1'b1, 3'd3, 1'b0, Z,  2'd0, 1'b1, 1'b1, 1'b1, 80'h8000, 3'd0, 1'b0, 16'h0},
        '{2'd2, 3'd0, 1'b0, 1'b1, 3'd5, 1'b0, Z,  2'd0, 1'b1, 1'b1, 1'b1, 80'h8000_0000_0000_0000, 3'd1, 1'b0, 16'h0},
        '{2'd2, 3'd0, 1'b0, 1'b1, 3'd1, 1'b0, Z,  2'd0, 1'b1, 1'b1, 1'b1, 80'hFFF8_0000_0000_0000, 3'd1, 1'b0, 16'h0},
        '{2'd2, 3'd0, 1'b0, 1'b1, 3'd2, 1'b0, Z,  2'd0, 1'b1, 1'b1, 1'b1, 80'hFFC0_0000, 3'd1, 1'b0, 16'h0},
        '{2'd2, 3'd0, 1'b0, 1'b1, 3'd4, 1'b0, Z,  2'd0, 1'b1, 1'b1, 1'b1, 80'h8000_0000, 3'd1, 1'b0, 16'h0},
        '{2'd2, 3'd0, 1'b0, 1'b1, 3'd6, 1'b0, Z,  2'd0, 1'b1, 1'b1, 1'b1, NAN,  3'd2, 1'b0, 16'h0},
        '{2'd3, 3'd3, 1'b0, 1'b0, 3'd0, 1'b0, Z,  2'd0, 1'b0, 1'b1, 1'b0, Z,    3'd2, 1'b1, 16'hFFFF}
    };

    function automatic string req_of(vec_t v);
        logic forced;
        forced = (v.fmt == 3'd0) || (v.fmt == 3'd5) || (v.fmt == 3'd6) || v.trunc;
        case (v.op)
            2'd0:    return "R2";
            2'd1:    return "R4";
            2'd2:    return v.e_fault ? (v.mask ? "R8" : "R7") : (forced ? "R9" : "R6");
            default: return v.e_fault ? "R7" : "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Present a command on a falling edge; it is taken on the next rising
    // edge and the results are read on the falling edge after that.
    task automatic issue(input logic [1:0] op, input logic [2:0] idx, input logic pop,
                         input logic mask, input logic [2:0] fmt, input logic trunc,
                         input logic [79:0] val, input logic [1:0] tag);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_idx   = idx;
        cmd_pop   = pop;
        cmd_mask  = mask;
        cmd_fmt   = fmt;
        cmd_trunc = trunc;
        cmd_val   = val;
        cmd_tag   = tag;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "tag_word", 80'(tag_word), 80'hFFFF);
        check("R1", "top_ptr", 80'(top_ptr), 80'd0);
        check("R1", "cmd_ready", 80'(cmd_ready), 80'd1);
        check("R1", "rsp_valid", 80'(rsp_valid), 80'd0);

        for (int k = 0; k < NV; k++) begin
            issue(VEC[k].op, VEC[k].idx, VEC[k].pop, VEC[k].mask, VEC[k].fmt,
                  VEC[k].trunc, VEC[k].val, VEC[k].tag);
            check("R11", $sformatf("v%0d rsp_valid", k), 80'(rsp_valid), 80'd1);
            check(req_of(VEC[k]), $sformatf("v%0d done", k), 80'(rsp_done), 80'(VEC[k].e_done));
            check(req_of(VEC[k]), $sformatf("v%0d fault", k), 80'(rsp_fault), 80'(VEC[k].e_fault));
            check(req_of(VEC[k]), $sformatf("v%0d st_we", k), 80'(st_we), 80'(VEC[k].e_we));
            if (VEC[k].e_we)
                check(req_of(VEC[k]), $sformatf("v%0d st_data", k), st_data, VEC[k].e_data);
            check(req_of(VEC[k]), $sformatf("v%0d top", k), 80'(top_ptr), 80'(VEC[k].e_top));
            if (VEC[k].chk_tags)
                check(req_of(VEC[k]), $sformatf("v%0d tags", k), 80'(tag_word), 80'(VEC[k].e_tags));
            if (VEC[k].op[1] == 1'b0)
                check("R5", $sformatf("v%0d c1", k), 80'(c1), 80'd0);
        end

        // R11: no command, no response
        @(negedge clk);
        check("R11", "idle rsp_valid", 80'(rsp_valid), 80'd0);

        // Build a gap: ST(0) and the slot below it occupied, ST(3) empty.
        issue(2'd0, 3'd0, 1'b0, 1'b1, 3'd0, 1'b0, VA, 2'd0);       // top 1
        issue(2'd3, 3'd7, 1'b0, 1'b1, 3'd0, 1'b0, Z, 2'd0);        // ST(7)=slot 0
        check("R10", "tags after store-to-reg", 80'(tag_word), 80'hFFF0);

        // R4/R3: overflow is reported ahead of the empty source
        issue(2'd1, 3'd3, 1'b0, 1'b1, 3'd0, 1'b0, Z, 2'd0);
        check("R4", "ovf precedence", 80'(rsp_ovf), 80'd1);
        check("R3", "ovf not done", 80'(rsp_done), 80'd0);
        check("R3", "ovf c1", 80'(c1), 80'd1);
        check("R3", "ovf top", 80'(top_ptr), 80'd1);
        check("R3", "ovf tags", 80'(tag_word), 80'hFFF0);

        // R3: plain push-load overflow, masked, still changes nothing
        issue(2'd0, 3'd0, 1'b0, 1'b1, 3'd0, 1'b0, VC, 2'd2);
        check("R3", "push ovf fault", 80'(rsp_fault), 80'd1);
        check("R3", "push ovf top", 80'(top_ptr), 80'd1);
        check("R3", "push ovf tags", 80'(tag_word), 80'hFFF0);

        // R10: pop with index 0 leaves the slot empty
        issue(2'd3, 3'd0, 1'b1, 1'b1, 3'd0, 1'b0, Z, 2'd0);
        check("R10", "idx0 pop done", 80'(rsp_done), 80'd1);
        check("R10", "idx0 pop top", 80'(top_ptr), 80'd2);
        check("R10", "idx0 pop tags", 80'(tag_word), 80'hFFFC);
        check("R5", "store keeps c1", 80'(c1), 80'd1);

        // R5/R2: a good load clears C1 and writes its tag
        issue(2'd0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, VC, 2'd2);
        check("R5", "c1 cleared", 80'(c1), 80'd0);
        check("R2", "push tag", 80'(tag_word), 80'hFFF8);
        check("R2", "push top", 80'(top_ptr), 80'd1);

        // R9/R6: extended store pops and returns the pushed word
        issue(2'd2, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, Z, 2'd0);
        check("R6", "ext store data", st_data, VC);
        check("R9", "ext store pops", 80'(top_ptr), 80'd2);
        check("R9", "ext store tags", 80'(tag_word), 80'hFFFC);

        finish_run();
    end

endmodule